// File: doc/BRIEF.md
# Double-Data-Rate Late-Write SRAM Protocol Engine

This block is a synthesizable model of the front end of a synchronous SRAM that moves two data words per clock. It samples the address, write strobe, advance strobe and three chip enables on the rising clock edge. A read is answered one cycle later on a pair of output buses. One bus carries the even word of the pair, which would be the rising-edge beat. The other carries the odd word, which would be the falling-edge beat. A write takes its two words in the cycle that follows the command. Word-address bit 0 is not an input: the rise bus always maps to word offset 0 and the fall bus to offset 1.

Of the three enables, one is always active low. The other two have their active level chosen by static polarity inputs. The device only acts in a cycle where all three enables are active. The echo-clock permission output drops only when one of the two polarity-programmable enables is inactive. An advance strobe held high continues the previous read or write at the other pair of a four-word block, so a burst wraps inside that block.

Top module: `ddr_sram_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_oe_o` and `echo_en_o` are 0.
- R2: A read command returns the stored pair in the next cycle. A read command is a rising edge with `adv_i`=0, `wr_n_i`=1 and the device selected. In the next cycle `rd_oe_o`=1, `rd_rise_o` carries word offset 0 and `rd_fall_o` carries word offset 1 of pair `addr_i`.
- R3: A write command stores the following cycle's data. A write command is a rising edge with `adv_i`=0, `wr_n_i`=0 and the device selected. The values on `wr_rise_i` and `wr_fall_i` at the next rising edge are stored as offsets 0 and 1 of that pair.
- R4: The device is selected only when `en1_n_i`=0, `en2_i`=`en2_pol_i` and `en3_i`=`en3_pol_i`. A polarity input of 1 means active high. Any other combination is a deselect: it performs no read and no write.
- R5: In the cycle after each rising edge, `echo_en_o` is 1 exactly when `en2_i` and `en3_i` were both active at that edge. The values of `en1_n_i` and of the command have no effect on it.
- R6: `rd_oe_o` is 1 only in the cycle after a read or a read continuation. It is 0 after writes, deselects and idle cycles.
- R7: Reads and writes may follow each other on consecutive cycles with no gap. A read issued right after a write to the same pair returns the newly written data.
- R8: An edge with `adv_i`=1 and the device selected repeats the previous read or write when the previous cycle carried one. The repeat uses the previous pair address with bit 0 inverted, so four words wrap within an aligned block. Otherwise such an edge is idle; this covers the first edge after reset and any edge after a deselect.
- R9: `wr_rise_i` and `wr_fall_i` have no effect except at the data edge of a write. The array contents read back afterwards are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Pair address (word address without bit 0) |
| wr_n_i | input | 1 | 0 = write, 1 = read |
| adv_i | input | 1 | 0 = load a new command, 1 = continue burst |
| en1_n_i | input | 1 | Chip enable, active low |
| en2_i | input | 1 | Chip enable, polarity from `en2_pol_i` |
| en3_i | input | 1 | Chip enable, polarity from `en3_pol_i` |
| en2_pol_i | input | 1 | Active level of `en2_i` |
| en3_pol_i | input | 1 | Active level of `en3_i` |
| wr_rise_i | input | DATA_W | Write word, offset 0 |
| wr_fall_i | input | DATA_W | Write word, offset 1 |
| rd_rise_o | output | DATA_W | Read word, offset 0 |
| rd_fall_o | output | DATA_W | Read word, offset 1 |
| rd_oe_o | output | 1 | Data bus would be driven this cycle |
| echo_en_o | output | 1 | Echo clocks are allowed to run |

## Verification
The first pattern writes every pair with data built from its address, then reads every pair back. A misrouted address or swapped beats shows up as a wrong value. All four polarity settings are then swept against all eight enable combinations. A write attempted under each combination is followed by a read with valid enables, which separates real deselects from false ones and checks the echo permission at every step. Interleaved write/read sequences to the same pair, with no idle cycles, expose any stale-data hazard. Bursts started at either pair of a block, and continuations issued after a deselect, check the wrap order and that an orphan continuation is ignored.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int unsigned BEATS = 2;
endpackage

// File: rtl/ddr_enable_decode.sv
module ddr_enable_decode #(
  parameter int unsigned N_PROG = 2
) (
  input  logic              en_fixed_n_i,
  input  logic [N_PROG-1:0] en_prog_i,
  input  logic [N_PROG-1:0] pol_i,
  output logic              sel_o,
  output logic              prog_ok_o
);
  logic [N_PROG-1:0] act;

  genvar gi;
  generate
    for (gi = 0; gi < N_PROG; gi++) begin : g_en
      assign act[gi] = (en_prog_i[gi] == pol_i[gi]);
    end
  endgenerate

  assign prog_ok_o = &act;
  assign sel_o     = prog_ok_o & ~en_fixed_n_i;
endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              wr_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    op_d   = OP_IDLE;
    addr_d = addr_q;
    if (sel_i) begin
      if (!adv_i) begin
        op_d   = wr_n_i ? OP_READ : OP_WRITE;
        addr_d = addr_i;
      end else if (op_q != OP_IDLE) begin
        op_d   = op_q;
        addr_d = addr_q ^ ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/ddr_pair_array.sv
module ddr_pair_array
  import ddr_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         we_i,
  input  logic                         re_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [BEATS-1:0][DATA_W-1:0] wdata_i,
  output logic [BEATS-1:0][DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  genvar gb;
  generate
    for (gb = 0; gb < BEATS; gb++) begin : g_beat
      logic [DATA_W-1:0] mem [DEPTH];
      logic [DATA_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i[gb];
        if (re_i) rd_q <= mem[addr_i];
      end

      assign rdata_o[gb] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/ddr_sram_engine.sv
module ddr_sram_engine
  import ddr_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_n_i,
  input  logic              adv_i,
  input  logic              en1_n_i,
  input  logic              en2_i,
  input  logic              en3_i,
  input  logic              en2_pol_i,
  input  logic              en3_pol_i,
  input  logic [DATA_W-1:0] wr_rise_i,
  input  logic [DATA_W-1:0] wr_fall_i,
  output logic [DATA_W-1:0] rd_rise_o,
  output logic [DATA_W-1:0] rd_fall_o,
  output logic              rd_oe_o,
  output logic              echo_en_o
);
  logic                         sel, prog_ok;
  op_e                          op;
  logic [ADDR_W-1:0]            op_addr;
  logic [BEATS-1:0][DATA_W-1:0] wdata, rdata;
  logic                         oe_q, echo_q;

  ddr_enable_decode #(.N_PROG(2)) u_en (
    .en_fixed_n_i (en1_n_i),
    .en_prog_i    ({en3_i, en2_i}),
    .pol_i        ({en3_pol_i, en2_pol_i}),
    .sel_o        (sel),
    .prog_ok_o    (prog_ok)
  );

  ddr_cmd_decode #(.ADDR_W(ADDR_W)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (sel),
    .adv_i  (adv_i),
    .wr_n_i (wr_n_i),
    .addr_i (addr_i),
    .op_o   (op),
    .addr_o (op_addr)
  );

  assign wdata[0] = wr_rise_i;
  assign wdata[1] = wr_fall_i;

  ddr_pair_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .we_i    (op == OP_WRITE),
    .re_i    (op == OP_READ),
    .addr_i  (op_addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      echo_q <= 1'b0;
    end else begin
      oe_q   <= (op == OP_READ);
      echo_q <= prog_ok;
    end
  end

  assign rd_rise_o = rdata[0];
  assign rd_fall_o = rdata[1];
  assign rd_oe_o   = oe_q;
  assign echo_en_o = echo_q;
endmodule

// File: rtl/ddr_sram_engine_chk.sv
module ddr_sram_engine_chk (
  input logic clk,
  input logic rst,
  input logic wr_n_i,
  input logic adv_i,
  input logic en1_n_i,
  input logic en2_i,
  input logic en3_i,
  input logic en2_pol_i,
  input logic en3_pol_i,
  input logic rd_oe_o,
  input logic echo_en_o
);
  logic [1:0] cyc;
  logic       pact, sel;

  assign pact = (en2_i == en2_pol_i) && (en3_i == en3_pol_i);
  assign sel  = pact && !en1_n_i;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!rd_oe_o && !echo_en_o));

  // R5
  a_r5_echo_follows_enables: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0) |-> (echo_en_o == $past(pact)));

  // R2
  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && $past(sel && !adv_i && wr_n_i, 2)) |-> rd_oe_o);

  // R6
  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && $past(sel && !adv_i && !wr_n_i, 2)) |-> !rd_oe_o);

  // R4
  a_r4_deselect_no_drive: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && $past(!sel, 2)) |-> !rd_oe_o);

  // R8
  a_r8_orphan_continue_idle: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(!sel, 3) && $past(adv_i, 2)) |-> !rd_oe_o);
endmodule

bind ddr_sram_engine ddr_sram_engine_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_n_i    (wr_n_i),
  .adv_i     (adv_i),
  .en1_n_i   (en1_n_i),
  .en2_i     (en2_i),
  .en3_i     (en3_i),
  .en2_pol_i (en2_pol_i),
  .en3_pol_i (en3_pol_i),
  .rd_oe_o   (rd_oe_o),
  .echo_en_o (echo_en_o)
);

// File: tb/ddr_sram_engine_tb.sv
module ddr_sram_engine_tb;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          wr_n_i, adv_i, en1_n_i, en2_i, en3_i, en2_pol_i, en3_pol_i;
  logic [DW-1:0] wr_rise_i, wr_fall_i, rd_rise_o, rd_fall_o;
  logic          rd_oe_o, echo_en_o;

  ddr_sram_engine #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model: 0 idle, 1 read, 2 write
  int            pend_op = 0;
  logic [AW-1:0] pend_addr = '0;
  logic [DW-1:0] em_r [NP];
  logic [DW-1:0] em_f [NP];
  logic [DW-1:0] q_r = 8'h5A, q_f = 8'hC3;
  int            gcnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, evaluate outputs at next negedge
  task automatic step(input logic adv, input logic wrn, input logic e1n,
                      input logic e2, input logic e3, input logic [AW-1:0] a);
    bit pact, sel;
    addr_i = a; adv_i = adv; wr_n_i = wrn;
    en1_n_i = e1n; en2_i = e2; en3_i = e3;
    wr_rise_i = q_r; wr_fall_i = q_f;
    @(posedge clk);
    @(negedge clk);
    pact = (e2 == en2_pol_i) && (e3 == en3_pol_i);
    sel  = pact && !e1n;
    if (pend_op == 2) begin
      em_r[pend_addr] = wr_rise_i;
      em_f[pend_addr] = wr_fall_i;
    end
    chk(rd_oe_o == (pend_op == 1), "R6 oe", rd_oe_o, pend_op == 1);
    if (pend_op == 1) begin
      chk(rd_rise_o == em_r[pend_addr], "R2 rise word", rd_rise_o, em_r[pend_addr]);
      chk(rd_fall_o == em_f[pend_addr], "R2 fall word", rd_fall_o, em_f[pend_addr]);
    end
    chk(echo_en_o == pact, "R5 echo", echo_en_o, pact);
    if (!sel) pend_op = 0;
    else if (!adv) begin
      pend_op = wrn ? 1 : 2;
      pend_addr = a;
    end else if (pend_op != 0) pend_addr = pend_addr ^ AW'(1);
    gcnt++;
    q_r = 8'hA5 ^ DW'(gcnt * 29);
    q_f = 8'h3C ^ DW'(gcnt * 13);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b0, 1'b1, 1'b0, en2_pol_i, en3_pol_i, a);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] r, input logic [DW-1:0] f);
    step(1'b0, 1'b0, 1'b0, en2_pol_i, en3_pol_i, a);
    q_r = r; q_f = f;
  endtask

  task automatic cont();
    step(1'b1, 1'b1, 1'b0, en2_pol_i, en3_pol_i, AW'(0));
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 1'b1, en2_pol_i, en3_pol_i, AW'(0));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; addr_i = '0; wr_n_i = 1'b1; adv_i = 1'b0;
    en1_n_i = 1'b0; en2_i = 1'b1; en3_i = 1'b1;
    en2_pol_i = 1'b1; en3_pol_i = 1'b1;
    wr_rise_i = '0; wr_fall_i = '0;
    repeat (3) @(negedge clk);
    chk(rd_oe_o == 1'b0, "R1 oe in reset", rd_oe_o, 0);
    chk(echo_en_o == 1'b0, "R1 echo in reset", echo_en_o, 0);
    rst = 1'b0;
    // R8: continuation as first command after reset is idle
    cont();
    // R3 / R2: fill and read back every pair
    for (int a = 0; a < NP; a++) wr(AW'(a), DW'(a * 37 + 5), DW'(~(a * 11)));
    idle();
    for (int a = 0; a < NP; a++) rd(AW'(a));
    // R7: back-to-back write/read on the same pair, no gaps
    for (int a = 0; a < NP; a++) begin
      wr(AW'(a), DW'(a * 3 + 100), DW'(a * 7 + 1));
      rd(AW'(a));
      wr(AW'(a ^ 1), DW'(a + 200), DW'(a + 50));
      rd(AW'(a ^ 1));
    end
    idle();
    // R4 / R5 / R9: polarity sweep against all enable patterns
    for (int p = 0; p < 4; p++) begin
      en2_pol_i = p[0]; en3_pol_i = p[1];
      for (int e = 0; e < 8; e++) begin
        step(1'b0, 1'b0, e[0], e[1], e[2], AW'(5));
        q_r = DW'(p * 16 + e); q_f = DW'(8'hF0 - e);
        step(1'b0, 1'b1, 1'b1, e[1], e[2], AW'(0));
        rd(AW'(5));
        idle();
      end
    end
    // R8: bursts from either pair, reads and writes
    wr(AW'(2), 8'h11, 8'h22); cont(); q_r = 8'h33; q_f = 8'h44;
    cont(); q_r = 8'h55; q_f = 8'h66;
    idle();
    rd(AW'(3)); cont(); cont(); cont();
    idle();
    // R8: continuation after a deselect stays idle, array unchanged
    cont(); cont();
    rd(AW'(2)); rd(AW'(3));
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule